// File: doc/BRIEF.md
# External Interrupt Sense and Mask Controller

This block conditions a set of external interrupt request pins and a non-maskable interrupt pin before they reach a priority resolver. Every pin first crosses a two-flop synchronizer. Each request source then goes through its own programmable detector, which can sense a falling edge, a rising edge or a low level. Edge-detected requests are held as pending until software or the resolver pulses a per-source clear strobe. Level-sensitive requests follow the synchronized pin on every cycle and are never latched.

A single 16-bit configuration word controls the block through a simple synchronous read/write port. A mode bit turns the four lowest request pins into one active-low 4-bit encoded level with values 1 to 15, instead of four separate requests. A global mask bit silences every maskable request while the synchronized NMI pin is low. A third bit decides whether NMI is still reported while the processor's block bit is set.

The block delivers three results to the resolver: per-source pending flags, the encoded external level and a qualified NMI request.

Top module: `xirq_sense_ctrl`

## Requirements
- R1: The configuration word reads 0x4000 after the asynchronous power-on reset (`rst_n` low) and one cycle after the synchronous manual reset (`man_rst` high). Both resets also clear all pending state.
- R2: A write (`reg_we` high) stores all 16 bits of `reg_wdata`, which read back on `reg_rdata` from the next cycle. Bit 12 and the spare bits are plain storage with no effect.
- R3: Source i takes its sense field from bits 2i+1:2i, with source 5 in bits 11:10 and source 0 in bits 1:0. The encodings are 00 falling edge, 01 rising edge, 10 low level, and 11 also low level. A source in edge mode ignores the opposite edge.
- R4: An edge seen on a synchronized pin sets that source's pending flag, which is visible 3 clock edges after the pin changes. The flag stays set until the clock edge that samples that source's `src_clr` bit high. If a new edge and a clear strike in the same cycle, the flag stays set.
- R5: A source in low-level mode shows pending exactly while its synchronized pin is low, 2 clock edges after the pin changes. It keeps no memory.
- R6: With bit 14 at 1, `irl_level` is the inverse of synchronized pins 3..0, where 0 means no request and 1 to 15 are levels, and `src_pend[3:0]` are 0 with no edge latched. With bit 14 at 0, `irl_level` is 0.
- R7: With bit 15 at 1 and the synchronized NMI pin low, `src_pend` and `irl_level` are all 0, while latched edges are kept. With the NMI pin high, or with bit 15 at 0, the mask has no effect.
- R8: A rising edge on the NMI pin latches an NMI pending flag that is cleared by `nmi_clr`. `nmi_req` is that flag, forced to 0 while `blk_bit` is 1 and bit 13 is 0. With bit 13 at 1, `blk_bit` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| man_rst | input | 1 | Synchronous manual reset, active high |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 16 | Configuration write data |
| reg_rdata | output | 16 | Current configuration word |
| irq_pin | input | 6 | Raw external request pins, asynchronous |
| nmi_pin | input | 1 | Raw NMI pin, asynchronous |
| blk_bit | input | 1 | Processor block bit |
| src_clr | input | 6 | Per-source pending clear strobes |
| nmi_clr | input | 1 | NMI pending clear strobe |
| src_pend | output | 6 | Qualified per-source pending flags |
| irl_level | output | 4 | Encoded external level, 0 = none |
| nmi_req | output | 1 | Qualified NMI request |

## Verification
Results fall due at three different points after a stimulus:
- A pin change reaches a latched edge flag on the third clock edge.
- A level-mode source, the encoded level and the NMI-pin mask respond on the second clock edge.
- Configuration writes, clear strobes and `blk_bit` act on the next edge, or combinationally for `blk_bit`.

The driver changes inputs just after a falling clock edge and waits exactly that many falling edges before it queues the expected item, which the monitor compares 1 ns later. One check is taken deliberately one edge early, where the edge flag must still be clear. The set-versus-clear case places the clear strobe in the one cycle where the edge is detected.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   // Sense field encoding, two bits per request source.
   typedef enum logic [1:0] {
      SNS_FALL = 2'b00,
      SNS_RISE = 2'b01,
      SNS_LOW  = 2'b10,
      SNS_RSVD = 2'b11
   } sense_e;

   localparam int SENSE_W = 2;

   // A sense field selects level detection when its upper bit is set.
   function automatic logic is_level(input logic [SENSE_W-1:0] f);
      return f[SENSE_W-1];
   endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int           W       = 7,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     stg[s] <= RST_VAL;
         else if (srst)  stg[s] <= RST_VAL;
         else if (s == 0) stg[s] <= d;
         else            stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xirq_cfg_reg.sv
module xirq_cfg_reg #(
   parameter int           W       = 16,
   parameter logic [W-1:0] RST_VAL = 16'h4000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (srst) q <= RST_VAL;
      else if (we)   q <= wdata;
   end
endmodule

// File: rtl/xirq_src_cell.sv
module xirq_src_cell
   import xirq_pkg::*;
#(
   parameter bit   ENCODABLE = 1'b0,
   parameter logic PREV_RST  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               srst,
   input  logic               pin_s,
   input  logic [SENSE_W-1:0] sense,
   input  logic               enc_mode,
   input  logic               clr,
   output logic               req
);
   logic prev_q, pend_q, pend_d;
   logic rise, fall, hit, lvl_mode, suppress;

   assign rise     = pin_s & ~prev_q;
   assign fall     = ~pin_s & prev_q;
   assign lvl_mode = is_level(sense);
   assign hit      = (sense == SNS_FALL) ? fall : rise;
   assign suppress = ENCODABLE & enc_mode;

   // A new edge wins over a clear strobe in the same cycle.
   always_comb begin
      if (lvl_mode || suppress) pend_d = 1'b0;
      else                      pend_d = hit | (pend_q & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= PREV_RST;
         pend_q <= 1'b0;
      end else if (srst) begin
         prev_q <= PREV_RST;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_s;
         pend_q <= pend_d;
      end
   end

   assign req = suppress ? 1'b0 : (lvl_mode ? ~pin_s : pend_q);
endmodule

// File: rtl/xirq_sense_ctrl.sv
module xirq_sense_ctrl
   import xirq_pkg::*;
#(
   parameter int NUM_SRC     = 6,
   parameter int ENC_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_W       = 16,
   parameter logic [CFG_W-1:0] CFG_RST = 16'h4000,
   parameter int ALLMASK_POS = 15,
   parameter int ENC_POS     = 14,
   parameter int NMIBLK_POS  = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               man_rst,
   input  logic               reg_we,
   input  logic [CFG_W-1:0]   reg_wdata,
   output logic [CFG_W-1:0]   reg_rdata,
   input  logic [NUM_SRC-1:0] irq_pin,
   input  logic               nmi_pin,
   input  logic               blk_bit,
   input  logic [NUM_SRC-1:0] src_clr,
   input  logic               nmi_clr,
   output logic [NUM_SRC-1:0] src_pend,
   output logic [ENC_W-1:0]   irl_level,
   output logic               nmi_req
);
   localparam int FIELD_TOP = NUM_SRC * SENSE_W;
   localparam int SYNC_W    = NUM_SRC + 1;
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, {NUM_SRC{1'b1}}};

   if (ENC_W > NUM_SRC) begin : g_bad_enc
      $error("ENC_W must not exceed NUM_SRC");
   end
   if (FIELD_TOP > NMIBLK_POS) begin : g_bad_fields
      $error("sense fields overlap the control bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [CFG_W-1:0]   cfg_q;
   logic [SYNC_W-1:0]  sync_q;
   logic [NUM_SRC-1:0] pin_s;
   logic               nmi_lvl;
   logic [NUM_SRC-1:0] src_raw;
   logic               nmi_hit;
   logic               all_mask, enc_mode, nmi_any, gate_all;

   xirq_cfg_reg #(.W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .srst(man_rst),
      .we(reg_we), .wdata(reg_wdata), .q(cfg_q)
   );

   xirq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .srst(man_rst),
      .d({nmi_pin, irq_pin}), .q(sync_q)
   );

   assign pin_s    = sync_q[NUM_SRC-1:0];
   assign nmi_lvl  = sync_q[NUM_SRC];
   assign all_mask = cfg_q[ALLMASK_POS];
   assign enc_mode = cfg_q[ENC_POS];
   assign nmi_any  = cfg_q[NMIBLK_POS];
   assign gate_all = all_mask & ~nmi_lvl;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i < ENC_W) begin : g_enc
         xirq_src_cell #(.ENCODABLE(1'b1), .PREV_RST(1'b1)) u_cell (
            .clk(clk), .rst_n(rst_n), .srst(man_rst), .pin_s(pin_s[i]),
            .sense(cfg_q[i*SENSE_W +: SENSE_W]), .enc_mode(enc_mode),
            .clr(src_clr[i]), .req(src_raw[i])
         );
      end else begin : g_plain
         xirq_src_cell #(.ENCODABLE(1'b0), .PREV_RST(1'b1)) u_cell (
            .clk(clk), .rst_n(rst_n), .srst(man_rst), .pin_s(pin_s[i]),
            .sense(cfg_q[i*SENSE_W +: SENSE_W]), .enc_mode(enc_mode),
            .clr(src_clr[i]), .req(src_raw[i])
         );
      end
   end

   xirq_src_cell #(.ENCODABLE(1'b0), .PREV_RST(1'b0)) u_nmi (
      .clk(clk), .rst_n(rst_n), .srst(man_rst), .pin_s(nmi_lvl),
      .sense(SNS_RISE), .enc_mode(1'b0), .clr(nmi_clr), .req(nmi_hit)
   );

   assign src_pend  = src_raw & {NUM_SRC{~gate_all}};
   assign irl_level = (enc_mode && !gate_all) ? ~pin_s[ENC_W-1:0] : '0;
   assign nmi_req   = nmi_hit & (nmi_any | ~blk_bit);
   assign reg_rdata = cfg_q;
endmodule

module xirq_sense_sva #(
   parameter int NUM_SRC = 6,
   parameter int ENC_W = 4,
   parameter int CFG_W = 16,
   parameter logic [CFG_W-1:0] CFG_RST = 16'h4000,
   parameter int ALLMASK_POS = 15,
   parameter int ENC_POS = 14,
   parameter int NMIBLK_POS = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               man_rst,
   input logic               reg_we,
   input logic [CFG_W-1:0]   reg_wdata,
   input logic [CFG_W-1:0]   reg_rdata,
   input logic               nmi_lvl,
   input logic               blk_bit,
   input logic [NUM_SRC-1:0] src_pend,
   input logic [ENC_W-1:0]   irl_level,
   input logic               nmi_req
);
   a_r1_manual_reset: assert property (@(posedge clk) disable iff (!rst_n)
      man_rst |=> reg_rdata == CFG_RST);
   a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !man_rst) |=> reg_rdata == $past(reg_wdata));
   a_r6_enc_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[ENC_POS] |-> src_pend[ENC_W-1:0] == '0);
   a_r6_indep_no_level: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[ENC_POS] |-> irl_level == '0);
   a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[ALLMASK_POS] && !nmi_lvl) |-> (src_pend == '0 && irl_level == '0));
   a_r8_nmi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_bit && !reg_rdata[NMIBLK_POS]) |-> !nmi_req);
endmodule

bind xirq_sense_ctrl xirq_sense_sva #(
   .NUM_SRC(NUM_SRC), .ENC_W(ENC_W), .CFG_W(CFG_W), .CFG_RST(CFG_RST),
   .ALLMASK_POS(ALLMASK_POS), .ENC_POS(ENC_POS), .NMIBLK_POS(NMIBLK_POS)
) u_sva (
   .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .reg_we(reg_we),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_lvl(nmi_lvl),
   .blk_bit(blk_bit), .src_pend(src_pend), .irl_level(irl_level),
   .nmi_req(nmi_req)
);

// File: tb/test_xirq_sense_ctrl.sv
module test_xirq_sense_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        man_rst = 1'b0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [5:0]  irq_pin = 6'h3F;
   logic        nmi_pin = 1'b0;
   logic        blk_bit = 1'b0;
   logic [5:0]  src_clr = '0;
   logic        nmi_clr = 1'b0;
   logic [5:0]  src_pend;
   logic [3:0]  irl_level;
   logic        nmi_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [5:0]  pend;
      logic [3:0]  lvl;
      logic        nmi;
      logic [15:0] cfg;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   xirq_sense_ctrl i_xirq_sense_ctrl (
      .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
      .nmi_pin(nmi_pin), .blk_bit(blk_bit), .src_clr(src_clr),
      .nmi_clr(nmi_clr), .src_pend(src_pend), .irl_level(irl_level),
      .nmi_req(nmi_req)
   );

   // Monitor: compares each queued expectation 1 ns after it is pushed.
   initial begin
      exp_t it;
      forever begin
         wait (sb_q.size() != 0);
         #1;
         it = sb_q.pop_front();
         n_cmp++;
         if (src_pend !== it.pend || irl_level !== it.lvl ||
             nmi_req !== it.nmi || reg_rdata !== it.cfg) begin
            n_bad++;
            $display("FAIL %s: pend=%b/%b lvl=%0d/%0d nmi=%b/%b cfg=%h/%h",
                     it.tag, src_pend, it.pend, irl_level, it.lvl,
                     nmi_req, it.nmi, reg_rdata, it.cfg);
         end
      end
   end

   task automatic expect_now(input logic [5:0] p, input logic [3:0] l,
                             input logic n, input logic [15:0] c, input string tag);
      exp_t e;
      e.pend = p; e.lvl = l; e.nmi = n; e.cfg = c; e.tag = tag;
      sb_q.push_back(e);
      #2;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(3);
      expect_now(6'b0, 4'd0, 1'b0, 16'h4000, "R1 power-on reset value");

      wr(16'h1000);
      expect_now(6'b0, 4'd0, 1'b0, 16'h1000, "R2 spare bit stored, no effect");
      // src5 rise, src4 fall, src3 rsvd(low), src2 low, src1 rise, src0 fall
      wr(16'h04E4);
      expect_now(6'b0, 4'd0, 1'b0, 16'h04E4, "R2 config readback");

      irq_pin[0] = 1'b0; step(2);
      expect_now(6'b0, 4'd0, 1'b0, 16'h04E4, "R4 edge not yet latched at 2 edges");
      step(1);
      expect_now(6'b000001, 4'd0, 1'b0, 16'h04E4, "R4 falling edge latched at 3 edges");
      irq_pin[0] = 1'b1; step(3);
      expect_now(6'b000001, 4'd0, 1'b0, 16'h04E4, "R4 pending held after pin release");
      irq_pin[1] = 1'b0; step(3);
      expect_now(6'b000001, 4'd0, 1'b0, 16'h04E4, "R3 falling edge ignored in rise mode");
      irq_pin[1] = 1'b1; step(3);
      expect_now(6'b000011, 4'd0, 1'b0, 16'h04E4, "R3 rising edge latched");

      irq_pin[2] = 1'b0; step(2);
      expect_now(6'b000111, 4'd0, 1'b0, 16'h04E4, "R5 low level seen");
      irq_pin[3] = 1'b0; step(2);
      expect_now(6'b001111, 4'd0, 1'b0, 16'h04E4, "R3 reserved code acts as low level");
      irq_pin[2] = 1'b1; step(2);
      expect_now(6'b001011, 4'd0, 1'b0, 16'h04E4, "R5 level not latched");
      irq_pin[3] = 1'b1; step(2);
      expect_now(6'b000011, 4'd0, 1'b0, 16'h04E4, "R5 reserved level released");

      src_clr = 6'b000001; step(1); src_clr = '0;
      expect_now(6'b000010, 4'd0, 1'b0, 16'h04E4, "R4 clear strobe");

      irq_pin[5] = 1'b0; step(3);
      irq_pin[5] = 1'b1; step(2);
      src_clr[5] = 1'b1; step(1); src_clr = '0;
      expect_now(6'b100010, 4'd0, 1'b0, 16'h04E4, "R4 edge wins over clear");
      src_clr = 6'b100010; step(1); src_clr = '0;
      expect_now(6'b000000, 4'd0, 1'b0, 16'h04E4, "R4 clear two sources");

      wr(16'h84E4);
      irq_pin[0] = 1'b0; irq_pin[2] = 1'b0; step(3);
      expect_now(6'b000000, 4'd0, 1'b0, 16'h84E4, "R7 all masked while NMI pin low");
      nmi_pin = 1'b1; step(2);
      expect_now(6'b000101, 4'd0, 1'b0, 16'h84E4, "R7 mask lifted, latched edge kept");
      step(1);
      expect_now(6'b000101, 4'd0, 1'b1, 16'h84E4, "R8 NMI rising edge latched");
      irq_pin[0] = 1'b1; irq_pin[2] = 1'b1; step(2);
      src_clr = 6'b000001; step(1); src_clr = '0;
      expect_now(6'b000000, 4'd0, 1'b1, 16'h84E4, "R8 NMI held");

      blk_bit = 1'b1;
      expect_now(6'b000000, 4'd0, 1'b0, 16'h84E4, "R8 NMI blocked by block bit");
      wr(16'hA4E4);
      expect_now(6'b000000, 4'd0, 1'b1, 16'hA4E4, "R8 block bit ignored with bit 13");
      nmi_clr = 1'b1; step(1); nmi_clr = 1'b0;
      expect_now(6'b000000, 4'd0, 1'b0, 16'hA4E4, "R8 NMI clear");
      blk_bit = 1'b0;

      wr(16'h44E4);
      irq_pin[3:0] = 4'b1010; step(2);
      expect_now(6'b000000, 4'd5, 1'b0, 16'h44E4, "R6 encoded level 5, no pend");
      irq_pin[3:0] = 4'b0000; step(2);
      expect_now(6'b000000, 4'd15, 1'b0, 16'h44E4, "R6 encoded level 15");
      wr(16'h04E4);
      expect_now(6'b001100, 4'd0, 1'b0, 16'h04E4, "R6 independent again, no stale edge");

      nmi_pin = 1'b0; step(2);
      wr(16'hC4E4);
      expect_now(6'b000000, 4'd0, 1'b0, 16'hC4E4, "R7 encoded level masked");
      wr(16'h44E4);
      expect_now(6'b000000, 4'd15, 1'b0, 16'h44E4, "R7 no mask when bit 15 clear");

      irq_pin = 6'h3F; step(3);
      man_rst = 1'b1; step(1); man_rst = 1'b0;
      expect_now(6'b000000, 4'd0, 1'b0, 16'h4000, "R1 manual reset value");

      wait (sb_q.size() == 0);
      #3;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule